// File: doc/BRIEF.md
# Bitmap Buffer Memory Allocator

This block hands out and takes back regions of a 16 KiB shared buffer memory. The memory is cut into 64 blocks of 256 bytes each. Occupancy lives in a bitmap of two 32-bit words, one bit per block. The buffer memory itself is not part of the block. Only its bookkeeping is.

A client raises one request at a time on a valid/ready handshake. An allocate request carries a byte size. The block finds a free run of blocks that is suitably aligned, marks that run as used, and reports the byte offset with a one-cycle done pulse. When no run is found, it reports the memory size, 16384, as the out-of-memory code. A free request carries an offset and a size, and the block clears the matching bits.

The search tests one candidate position per clock. While it runs, `reqReady` stays low. A synchronous clear input empties the whole bitmap and drops any request in flight.

Top module: `buf_block_alloc`

## Requirements
- R1: After reset, or in the cycle after `clearAll` is high, every block is free, `reqReady` is high and `doneValid` is low. The first 256-byte allocation after either event returns offset 0.
- R2: An allocation claims ceil(size/256) contiguous blocks. A 257-byte request therefore occupies two blocks.
- R3: The alignment stride is the smallest p in {1,2,4,8,16,32} with size <= 256*p. Candidate block indices are the multiples of p, tested in ascending order. The first candidate whose run is entirely free wins.
- R4: Candidates are taken from bitmap word 0 (blocks 0..31) before word 1 (blocks 32..63). A claimed run never straddles the two words.
- R5: `doneOffset` reports 16384 (out of memory) in three cases: size 0, size above 8192, or no aligned free run.
- R6: A successful allocation returns block index times 256 and marks those blocks used, so later allocations avoid them.
- R7: A free request with offset o and size s clears ceil(s/256) bits. The run starts at bit (o/256) mod 32 of word (o/256)/32. Bits that would pass bit 31 are dropped, and a word index of 2 or more changes nothing. Clearing free blocks leaves all other bits unchanged. The done pulse of a free request echoes o.
- R8: One candidate is evaluated per clock. An allocation decided at candidate k (counted from 0) pulses `doneValid` k+1 cycles after acceptance. A failure after all N = 64/p candidates pulses after N cycles. An invalid size pulses after 1 cycle, and a free request pulses after 1 cycle. `reqReady` is low from acceptance until the decision.
- R9: `doneValid` lasts exactly one cycle. `reqReady` is high in that same cycle, so a new request can be accepted while the previous result is presented.
- R10: `clearAll` in the middle of a search abandons the request without a done pulse. A later allocation sees an empty bitmap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearAll | input | 1 | Synchronous wipe of the bitmap and any pending request |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqFree | input | 1 | 1 = free request, 0 = allocate request |
| reqSize | input | 16 | Request size in bytes |
| reqOffset | input | 15 | Byte offset to release (free requests only) |
| doneValid | output | 1 | One-cycle completion pulse |
| doneOffset | output | 15 | Allocated offset, 16384 for failure, or echoed free offset |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this by holding `reqValid` high across several free requests. It then expects done pulses on alternating cycles, with each new acceptance landing in a done cycle.

A second collision is `clearAll` arriving while a long search is walking a full word 0. For that case the bench expects no done pulse at all, followed by an allocation that returns offset 0.

A behavioural reference model with a per-block array judges `doneValid`, `reqReady` and `doneOffset` on every clock.

// File: rtl/buf_alloc_pkg.sv
package buf_alloc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_UNCLAIM
  } alloc_state_t;

  // Strobes from the sequencer to the bitmap datapath
  typedef struct packed {
    logic load;     // capture request fields
    logic step;     // move to next aligned candidate
    logic claim;    // set the candidate run, report its offset
    logic fail;     // report out-of-memory
    logic unclaim;  // clear the run named by a free request
    logic wipe;     // empty the whole bitmap
  } alloc_strb_t;

endpackage

// File: rtl/buf_alloc_dp.sv
module buf_alloc_dp
  import buf_alloc_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int MAP_WORDS = 2,
  parameter int WORD_BITS = 32,
  parameter int SIZE_W    = 16,
  localparam int BLOCKS   = MAP_WORDS * WORD_BITS,
  localparam int IDX_W    = $clog2(BLOCKS),
  localparam int OFF_W    = $clog2(MEM_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  alloc_strb_t       strb,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [IDX_W-1:0]  candIdx,
  output logic              sizeOk,
  output logic              candFree,
  output logic [IDX_W:0]    stepBlocks,
  output logic [OFF_W-1:0]  doneOffset
);

  localparam int BLK_BYTES = MEM_BYTES / BLOCKS;
  localparam int BLK_SH    = $clog2(BLK_BYTES);
  localparam int POS_W     = $clog2(WORD_BITS);
  localparam int WSEL_W    = IDX_W - POS_W;
  localparam int FB_W      = OFF_W - BLK_SH;
  localparam int FW_W      = FB_W - POS_W;
  localparam int CNT_W     = SIZE_W - BLK_SH + 1;
  localparam int SL_W      = $clog2(POS_W + 1);

  logic [SIZE_W-1:0]    sizeReg;
  logic [OFF_W-1:0]     offReg;
  logic [WORD_BITS-1:0] mapR [MAP_WORDS];

  // block count: size rounded up to whole blocks
  logic [SIZE_W:0]      sumR;
  logic [CNT_W-1:0]     blkCnt;
  assign sumR   = {1'b0, sizeReg} + (SIZE_W + 1)'(BLK_BYTES - 1);
  assign blkCnt = sumR[SIZE_W:BLK_SH];

  // smallest power-of-two stride whose span covers the request
  logic            strideFound;
  logic [SL_W-1:0] strideLog;
  always_comb begin
    strideFound = 1'b0;
    strideLog   = '0;
    for (int i = 0; i <= POS_W; i++) begin
      if (!strideFound && (32'(sizeReg) <= (32'(BLK_BYTES) << i))) begin
        strideFound = 1'b1;
        strideLog   = SL_W'(i);
      end
    end
  end

  assign sizeOk     = strideFound && (sizeReg != '0);
  assign stepBlocks = (IDX_W + 1)'(1) << strideLog;

  // contiguous run of blkCnt ones, saturated at a full word
  logic [WORD_BITS-1:0] runMask;
  always_comb begin
    for (int b = 0; b < WORD_BITS; b++) begin
      runMask[b] = (blkCnt > CNT_W'(b));
    end
  end

  // candidate test
  logic [WSEL_W-1:0]    candWord;
  logic [POS_W-1:0]     candPos;
  logic [WORD_BITS-1:0] candMask;
  assign candWord = candIdx[IDX_W-1:POS_W];
  assign candPos  = candIdx[POS_W-1:0];
  assign candMask = runMask << candPos;
  assign candFree = ((mapR[candWord] & candMask) == '0);

  // free target
  logic [FB_W-1:0]      freeBlk;
  logic [FW_W-1:0]      freeWord;
  logic [POS_W-1:0]     freePos;
  logic [WORD_BITS-1:0] freeMask;
  assign freeBlk  = offReg[OFF_W-1:BLK_SH];
  assign freeWord = freeBlk[FB_W-1:POS_W];
  assign freePos  = freeBlk[POS_W-1:0];
  assign freeMask = runMask << freePos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg <= '0;
      offReg  <= '0;
    end else if (strb.load) begin
      sizeReg <= reqSize;
      offReg  <= reqOffset;
    end
  end

  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mapR[w] <= '0;
      end else if (strb.wipe) begin
        mapR[w] <= '0;
      end else if (strb.claim && (candWord == WSEL_W'(w))) begin
        mapR[w] <= mapR[w] | candMask;
      end else if (strb.unclaim && (freeWord == FW_W'(w))) begin
        mapR[w] <= mapR[w] & ~freeMask;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOffset <= '0;
    end else if (strb.wipe) begin
      doneOffset <= '0;
    end else if (strb.claim) begin
      doneOffset <= OFF_W'({candIdx, {BLK_SH{1'b0}}});
    end else if (strb.fail) begin
      doneOffset <= OFF_W'(MEM_BYTES);
    end else if (strb.unclaim) begin
      doneOffset <= offReg;
    end
  end

endmodule

// File: rtl/buf_alloc_ctrl.sv
module buf_alloc_ctrl
  import buf_alloc_pkg::*;
#(
  parameter int BLOCKS = 64,
  localparam int IDX_W = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearAll,
  input  logic             reqValid,
  input  logic             reqFree,
  input  logic             sizeOk,
  input  logic             candFree,
  input  logic [IDX_W:0]   stepBlocks,
  output logic             reqReady,
  output logic             doneValid,
  output logic [IDX_W-1:0] candIdx,
  output alloc_strb_t      strb
);

  alloc_state_t state, nxt;
  logic         lastCand;

  assign lastCand = (({1'b0, candIdx} + stepBlocks) >= (IDX_W + 1)'(BLOCKS));
  assign reqReady = (state == ST_IDLE) && !clearAll;

  always_comb begin
    strb = '0;
    nxt  = state;
    if (clearAll) begin
      strb.wipe = 1'b1;
      nxt       = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            strb.load = 1'b1;
            nxt       = reqFree ? ST_UNCLAIM : ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          nxt = ST_IDLE;
          if (!sizeOk) begin
            strb.fail = 1'b1;
          end else if (candFree) begin
            strb.claim = 1'b1;
          end else if (lastCand) begin
            strb.fail = 1'b1;
          end else begin
            strb.step = 1'b1;
            nxt       = ST_SEARCH;
          end
        end
        ST_UNCLAIM: begin
          strb.unclaim = 1'b1;
          nxt          = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
      candIdx   <= '0;
    end else begin
      state     <= nxt;
      doneValid <= strb.claim | strb.fail | strb.unclaim;
      if (strb.load) begin
        candIdx <= '0;
      end else if (strb.step) begin
        candIdx <= candIdx + stepBlocks[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/buf_block_alloc.sv
module buf_block_alloc
  import buf_alloc_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int MAP_WORDS = 2,
  parameter int WORD_BITS = 32,
  parameter int SIZE_W    = 16,
  localparam int OFF_W    = $clog2(MEM_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqFree,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [OFF_W-1:0]  reqOffset,
  output logic              doneValid,
  output logic [OFF_W-1:0]  doneOffset
);

  localparam int BLOCKS = MAP_WORDS * WORD_BITS;
  localparam int IDX_W  = $clog2(BLOCKS);

  alloc_strb_t      strb;
  logic             sizeOk;
  logic             candFree;
  logic [IDX_W:0]   stepBlocks;
  logic [IDX_W-1:0] candIdx;

  buf_alloc_ctrl #(
    .BLOCKS(BLOCKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearAll  (clearAll),
    .reqValid  (reqValid),
    .reqFree   (reqFree),
    .sizeOk    (sizeOk),
    .candFree  (candFree),
    .stepBlocks(stepBlocks),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .candIdx   (candIdx),
    .strb      (strb)
  );

  buf_alloc_dp #(
    .MEM_BYTES(MEM_BYTES),
    .MAP_WORDS(MAP_WORDS),
    .WORD_BITS(WORD_BITS),
    .SIZE_W   (SIZE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqSize   (reqSize),
    .reqOffset (reqOffset),
    .candIdx   (candIdx),
    .sizeOk    (sizeOk),
    .candFree  (candFree),
    .stepBlocks(stepBlocks),
    .doneOffset(doneOffset)
  );

endmodule

// File: rtl/buf_block_alloc_chk.sv
module buf_block_alloc_chk (
  input logic clk,
  input logic rstN,
  input logic clearAll,
  input logic reqValid,
  input logic reqReady,
  input logic doneValid
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !clearAll) |-> reqReady);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneValid) |-> $past(!reqReady));

  // R10
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> !doneValid);

endmodule

bind buf_block_alloc buf_block_alloc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clearAll (clearAll),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .doneValid(doneValid)
);

// File: tb/buf_block_alloc_tb.sv
module buf_block_alloc_tb;

  localparam int MEM = 16384;
  localparam int NBLK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearAll = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqFree = 1'b0;
  logic [15:0] reqSize = '0;
  logic [14:0] reqOffset = '0;
  logic        reqReady;
  logic        doneValid;
  logic [14:0] doneOffset;

  always #2 clk = ~clk;

  buf_block_alloc u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .clearAll  (clearAll),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqFree   (reqFree),
    .reqSize   (reqSize),
    .reqOffset (reqOffset),
    .doneValid (doneValid),
    .doneOffset(doneOffset)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit mMap[NBLK];
  int mCnt = 0;
  int mPend = 0;
  int mOff = 0;
  bit mDone = 0;

  function automatic void modelAccept(bit f, int sz, int off);
    if (f) begin
      int blk = off / 256;
      int n = (sz + 255) / 256;
      int w = blk / 32;
      if (w < 2) begin
        for (int j = 0; j < n; j++) begin
          int b = (blk % 32) + j;
          if (b < 32) mMap[w * 32 + b] = 0;
        end
      end
      mPend = off;
      mCnt = 1;
    end else if (sz == 0 || sz > 8192) begin
      mPend = MEM;
      mCnt = 1;
    end else begin
      int n = (sz + 255) / 256;
      int p = 1;
      int k = 0;
      bit hit = 0;
      while (sz > 256 * p) p = p * 2;
      for (int idx = 0; idx < NBLK && !hit; idx += p) begin
        bit busy = 0;
        for (int j = 0; j < n; j++) if (mMap[idx + j]) busy = 1;
        if (!busy) begin
          hit = 1;
          for (int j = 0; j < n; j++) mMap[idx + j] = 1;
          mPend = idx * 256;
          mCnt = k + 1;
        end
        k++;
      end
      if (!hit) begin
        mPend = MEM;
        mCnt = NBLK / p;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN || clearAll) begin
      for (int i = 0; i < NBLK; i++) mMap[i] = 0;
      mCnt = 0;
      mDone = 0;
    end else begin
      mDone = 0;
      if (mCnt > 0) begin
        mCnt--;
        if (mCnt == 0) begin
          mDone = 1;
          mOff = mPend;
        end
      end else if (reqValid) begin
        modelAccept(reqFree, int'(reqSize), int'(reqOffset));
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(doneValid == mDone, "R8 done timing", doneValid, mDone);
      check(reqReady == (mCnt == 0 && !clearAll), "R9 ready", reqReady, (mCnt == 0 && !clearAll));
      if (mDone) check(int'(doneOffset) == mOff, "R6 offset vs model", doneOffset, mOff);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  // ---------------- drivers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic doReq(input bit f, input int sz, input int off, output int got, output int lat);
    while (!reqReady) tick();
    reqValid = 1'b1;
    reqFree = f;
    reqSize = sz[15:0];
    reqOffset = off[14:0];
    tick();
    reqValid = 1'b0;
    lat = 0;
    while (!doneValid) begin
      tick();
      lat++;
    end
    got = int'(doneOffset);
  endtask

  task automatic expectAlloc(input int sz, input int exp, input string tag);
    int got, lat;
    doReq(1'b0, sz, 0, got, lat);
    check(got == exp, tag, got, exp);
  endtask

  task automatic expectFree(input int off, input int sz, input string tag);
    int got, lat;
    doReq(1'b1, sz, off, got, lat);
    check(got == off, tag, got, off);
  endtask

  task automatic wipe();
    clearAll = 1'b1;
    tick();
    clearAll = 1'b0;
    tick();
  endtask

  initial begin
    int got, lat, pulses;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(doneValid == 1'b0, "R1 done after reset", doneValid, 0);
    expectAlloc(256, 0, "R1 first alloc after reset");
    expectAlloc(257, 512, "R2 two-block run at stride 2");
    expectAlloc(100, 256, "R3 stride 1 fills gap");
    expectAlloc(600, 1024, "R3 stride 4 alignment");
    expectAlloc(0, MEM, "R5 zero size");
    expectAlloc(8193, MEM, "R5 oversize");
    expectAlloc(65535, MEM, "R5 max size");
    expectFree(512, 257, "R7 free echo");
    expectAlloc(512, 512, "R7 freed run reused");
    expectFree(4096, 256, "R7 free of unused block");
    expectAlloc(256, 1792, "R7 other bits kept");

    // R1 clear then whole-word allocations
    wipe();
    check(reqReady == 1'b1 && doneValid == 1'b0, "R1 idle after clear", reqReady, 1);
    expectAlloc(8192, 0, "R4 word 0 first");
    expectAlloc(8192, 8192, "R4 then word 1");
    expectAlloc(8192, MEM, "R5 no free run");

    // R4 no straddling across the word boundary
    wipe();
    for (int i = 0; i < 31; i++) expectAlloc(256, i * 256, "R6 sequential blocks");
    expectAlloc(512, 8192, "R4 run not split over words");
    expectAlloc(256, 7936, "R6 last block of word 0");
    expectFree(7936, 512, "R7 free at word edge");
    expectAlloc(256, 7936, "R7 edge block freed");
    expectAlloc(256, 8704, "R7 word 1 untouched by overrun");

    // R8 latency over a full word 0
    wipe();
    expectAlloc(8192, 0, "R8 setup");
    doReq(1'b0, 256, 0, got, lat);
    check(got == 8192, "R4 search moves to word 1", got, 8192);
    check(lat == 33, "R8 one candidate per cycle", lat, 33);

    // R10 clear during search
    wipe();
    expectAlloc(8192, 0, "R10 setup");
    while (!reqReady) tick();
    reqValid = 1'b1; reqFree = 1'b0; reqSize = 16'd256;
    tick();
    reqValid = 1'b0;
    repeat (4) tick();
    clearAll = 1'b1;
    tick();
    clearAll = 1'b0;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (doneValid) pulses++;
    end
    check(pulses == 0, "R10 abandoned request silent", pulses, 0);
    expectAlloc(256, 0, "R10 bitmap emptied");

    // R9 back-to-back: done and next accept share a cycle
    while (!reqReady) tick();
    reqValid = 1'b1; reqFree = 1'b1; reqSize = 16'd0; reqOffset = 15'd100;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (doneValid) pulses++;
    end
    reqValid = 1'b0;
    tick();
    check(pulses == 4, "R9 alternating done pulses", pulses, 4);

    repeat (3) tick();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule